// File: doc/BRIEF.md
# Watchdog Frequency Recovery Controller

This block decides which frequency setting a programmable clock synthesizer runs at. In normal operation the active 5-bit frequency code comes either from the hardware strap pins or from a software select register. The strap pins are captured on the first clock after reset and are not sampled again. A control bit chooses between the two sources. Registers are written through plain write strobes driven by a separate bus slave.

Software can arm a watchdog that counts down from a reload value. It decrements once every `TICK_DIV` reference clocks. If software does not restart it in time, the block enters a sticky recovery state. In that state it drives a recovery setting: either the captured strap code or an 8-bit N / 7-bit M divider pair. It also emits a system reset pulse and refuses every register write that would alter the output frequency. Software leaves recovery by writing the watchdog enable bit to 0. The same reset pulse can optionally follow a register write that changes the active frequency.

Control register layout (`ctrl_wdata_i`): bit 0 = software source select, bit 1 = watchdog enable, bit 2 = recovery from N/M, bit 3 = reset on frequency change.

Top module: `wfr_top`

## Requirements
- R1: While reset is held, `strap_q_o`, `freq_code_o`, `div_mode_o`, `sys_rst_o` and `recovery_o` are all 0.
- R2: `strap_i` is captured on the first clock edge after reset release and is shown on `strap_q_o`. Later changes on `strap_i` change neither `strap_q_o` nor the output frequency.
- R3: Outside recovery, `div_mode_o` is 0. `freq_code_o` equals the captured strap code when control bit 0 is 0, and the select register when bit 0 is 1. Control bit 2 has no effect outside recovery.
- R4: A control write that takes bit 1 from 0 to 1 loads the watchdog with the reload value. With reload R ≥ 1, time-out occurs on the R·`TICK_DIV`-th clock edge after that write edge.
- R5: A write to the reload register restarts the count from the new value. Time-out then follows R·`TICK_DIV` edges after the reload write.
- R6: On time-out, `recovery_o` becomes 1 and stays 1 until software clears bit 1. With control bit 2 = 0 the output becomes the strap code (`div_mode_o`=0). With bit 2 = 1, `div_mode_o`=1 and `div_n_o`/`div_m_o` carry the recovery N/M registers.
- R7: Each time-out raises `sys_rst_o` for exactly `PULSE_LEN` clock cycles, starting after the time-out edge, and only once per time-out.
- R8: When control bit 3 is already set outside recovery, a register write that changes the frequency outputs starts the same `PULSE_LEN`-cycle pulse. A write that leaves them unchanged does not.
- R9: In recovery, writes to the select, N and M registers are ignored. A control write updates only bit 1; the other control bits keep their values.
- R10: A control write with bit 1 = 0 leaves recovery. The output returns to the normal source chosen by the retained control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_i | input | 5 | Hardware frequency strap pins |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 4 | Control register write data |
| sel_we_i | input | 1 | Software select register write strobe |
| sel_wdata_i | input | 5 | Software select write data |
| rcv_n_we_i | input | 1 | Recovery N register write strobe |
| rcv_n_wdata_i | input | 8 | Recovery N write data |
| rcv_m_we_i | input | 1 | Recovery M register write strobe |
| rcv_m_wdata_i | input | 7 | Recovery M write data |
| reload_we_i | input | 1 | Watchdog reload register write strobe |
| reload_wdata_i | input | RELOAD_W | Watchdog reload write data |
| strap_q_o | output | 5 | Captured strap value (read-only) |
| freq_code_o | output | 5 | Active frequency code |
| div_mode_o | output | 1 | 1 when the N/M divider pair is in use |
| div_n_o | output | 8 | Active N divider (0 unless div_mode_o) |
| div_m_o | output | 7 | Active M divider (0 unless div_mode_o) |
| sys_rst_o | output | 1 | System reset pulse |
| recovery_o | output | 1 | Sticky recovery status |

## Verification
A table of control and select patterns tries the source multiplexer several ways: strap against software source, several select codes including 0, and the recovery-source bit set outside recovery. Together these show that bit 0 alone steers the output. Watchdog runs with reload values 2, 3 and 4 are sampled one edge before and on the predicted time-out edge, so an off-by-one tick count or a missed restart is visible. Writes during recovery, followed by exit, show at the ports whether the lockout dropped the data or merely hid it. Same-value and changing writes with the change-reset bit set separate a real frequency change from a bare write strobe.

// File: rtl/wfr_pkg.sv
package wfr_pkg;

    localparam int CODE_W = 5;
    localparam int N_W    = 8;
    localparam int M_W    = 7;
    localparam int CTRL_W = 4;

    // control word; sw_src is bit 0
    typedef struct packed {
        logic rst_on_chg;
        logic rcv_nm;
        logic wd_en;
        logic sw_src;
    } ctrl_t;

    typedef struct packed {
        logic              nm_mode;
        logic [CODE_W-1:0] code;
        logic [N_W-1:0]    n;
        logic [M_W-1:0]    m;
    } freq_t;

    function automatic freq_t pick_freq(
        input ctrl_t             c,
        input logic              recov,
        input logic [CODE_W-1:0] strap,
        input logic [CODE_W-1:0] sel,
        input logic [N_W-1:0]    n,
        input logic [M_W-1:0]    m
    );
        freq_t f;
        f = '0;
        if (recov) begin
            if (c.rcv_nm) begin
                f.nm_mode = 1'b1;
                f.n       = n;
                f.m       = m;
            end else begin
                f.code = strap;
            end
        end else begin
            f.code = c.sw_src ? sel : strap;
        end
        return f;
    endfunction

endpackage

// File: rtl/wfr_tick_gen.sv
module wfr_tick_gen #(
    parameter int TICK_DIV = 4096
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    output logic tick_o
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    assign tick_o = (s_q.cnt == LAST);

    always_comb begin
        s_d = s_q;
        if (clear_i || tick_o) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    generate
        if (TICK_DIV > 1) begin : g_spacing
            // R4: ticks are never back to back when the divider exceeds 1
            assert_tick_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/wfr_countdown.sv
module wfr_countdown #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    assign expire_o = run_i && tick_i && !load_i && (s_q.cnt <= CNT_W'(1));

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.cnt = load_val_i;
        end else if (run_i && tick_i && (s_q.cnt > CNT_W'(1))) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R5: a load always restarts from the supplied value
    assert_load_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (s_q.cnt == $past(load_val_i)));

    // R7: an expiry freezes the watchdog, so it never fires twice in a row
    assert_single_expire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |=> !expire_o);

endmodule

// File: rtl/wfr_rst_pulse.sv
module wfr_rst_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_i,
    output logic rst_o
);
    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(PULSE_LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    assign rst_o = (s_q.cnt != '0);

    always_comb begin
        s_d = s_q;
        if (fire_i) begin
            s_d.cnt = FULL;
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R7: the pulse counter never exceeds its length and shrinks by one per cycle
    assert_pulse_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt <= FULL);
    assert_pulse_shrink_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_o && !fire_i) |=> (s_q.cnt == $past(s_q.cnt) - CW'(1)));

endmodule

// File: rtl/wfr_top.sv
module wfr_top
    import wfr_pkg::*;
#(
    parameter int TICK_DIV  = 4096,
    parameter int RELOAD_W  = 16,
    parameter int PULSE_LEN = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [4:0]          strap_i,
    input  logic                ctrl_we_i,
    input  logic [3:0]          ctrl_wdata_i,
    input  logic                sel_we_i,
    input  logic [4:0]          sel_wdata_i,
    input  logic                rcv_n_we_i,
    input  logic [7:0]          rcv_n_wdata_i,
    input  logic                rcv_m_we_i,
    input  logic [6:0]          rcv_m_wdata_i,
    input  logic                reload_we_i,
    input  logic [RELOAD_W-1:0] reload_wdata_i,
    output logic [4:0]          strap_q_o,
    output logic [4:0]          freq_code_o,
    output logic                div_mode_o,
    output logic [7:0]          div_n_o,
    output logic [6:0]          div_m_o,
    output logic                sys_rst_o,
    output logic                recovery_o
);

    typedef struct packed {
        ctrl_t               ctrl;
        logic                recov;
        logic                latched;
        logic [CODE_W-1:0]   strap;
        logic [CODE_W-1:0]   sel;
        logic [N_W-1:0]      n;
        logic [M_W-1:0]      m;
        logic [RELOAD_W-1:0] reload;
    } st_t;

    st_t   s_d, s_q;
    ctrl_t wr_ctrl;
    freq_t freq_now, freq_nxt;
    logic  arm, disarm, any_we, chg_fire, timeout_ev;
    logic  tick, expire, wd_run, wd_load;
    logic [RELOAD_W-1:0] wd_load_val;

    assign wr_ctrl     = ctrl_t'(ctrl_wdata_i);
    assign wd_run      = s_q.ctrl.wd_en && !s_q.recov;
    assign arm         = ctrl_we_i && wr_ctrl.wd_en && !s_q.ctrl.wd_en;
    assign disarm      = ctrl_we_i && !wr_ctrl.wd_en;
    assign wd_load     = arm || reload_we_i;
    assign wd_load_val = reload_we_i ? reload_wdata_i : s_q.reload;
    assign timeout_ev  = expire && !disarm;
    assign any_we      = ctrl_we_i || sel_we_i || rcv_n_we_i || rcv_m_we_i;

    wfr_tick_gen #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (wd_load),
        .tick_o  (tick)
    );

    wfr_countdown #(
        .CNT_W (RELOAD_W)
    ) u_count (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (wd_run),
        .load_i     (wd_load),
        .load_val_i (wd_load_val),
        .tick_i     (tick),
        .expire_o   (expire)
    );

    wfr_rst_pulse #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .fire_i (timeout_ev || chg_fire),
        .rst_o  (sys_rst_o)
    );

    always_comb begin
        s_d = s_q;

        // one-time capture of the strap pins
        if (!s_q.latched) begin
            s_d.strap   = strap_i;
            s_d.latched = 1'b1;
        end

        if (ctrl_we_i) begin
            if (s_q.recov) begin
                s_d.ctrl.wd_en = wr_ctrl.wd_en;
            end else begin
                s_d.ctrl = wr_ctrl;
            end
            if (!wr_ctrl.wd_en) begin
                s_d.recov = 1'b0;
            end
        end

        if (sel_we_i && !s_q.recov) begin
            s_d.sel = sel_wdata_i;
        end
        if (rcv_n_we_i && !s_q.recov) begin
            s_d.n = rcv_n_wdata_i;
        end
        if (rcv_m_we_i && !s_q.recov) begin
            s_d.m = rcv_m_wdata_i;
        end
        if (reload_we_i) begin
            s_d.reload = reload_wdata_i;
        end

        if (timeout_ev) begin
            s_d.recov = 1'b1;
        end

        freq_now = pick_freq(s_q.ctrl, s_q.recov, s_q.strap, s_q.sel, s_q.n, s_q.m);
        freq_nxt = pick_freq(s_d.ctrl, s_d.recov, s_d.strap, s_d.sel, s_d.n, s_d.m);
        chg_fire = any_we && s_q.ctrl.rst_on_chg && !s_q.recov && !s_d.recov
                   && (freq_nxt != freq_now);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign strap_q_o   = s_q.strap;
    assign freq_code_o = freq_now.code;
    assign div_mode_o  = freq_now.nm_mode;
    assign div_n_o     = freq_now.n;
    assign div_m_o     = freq_now.m;
    assign recovery_o  = s_q.recov;

    // R2: once captured, the strap value never moves
    assert_strap_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.latched |=> $stable(s_q.strap));

    // R6: recovery is held until a control write clears the enable bit
    assert_recovery_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.recov && !disarm) |=> s_q.recov);

    // R9: select / N / M registers are locked during recovery
    assert_lock_sel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.recov && sel_we_i) |=> (s_q.sel == $past(s_q.sel)));
    assert_lock_nm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.recov && (rcv_n_we_i || rcv_m_we_i)) |=>
        ((s_q.n == $past(s_q.n)) && (s_q.m == $past(s_q.m))));

    // R3: outside recovery the divider pair is never in use
    assert_no_nm_normal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !recovery_o |-> !div_mode_o);

endmodule

// File: tb/tb_wfr_top.sv
module tb_wfr_top;

    localparam int TD  = 8;
    localparam int PL  = 16;
    localparam int RW  = 8;
    localparam logic [4:0] STRAP = 5'h13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    strap = STRAP;
    logic          ctrl_we = 0, sel_we = 0, n_we = 0, m_we = 0, rl_we = 0;
    logic [3:0]    ctrl_wd = '0;
    logic [4:0]    sel_wd = '0;
    logic [7:0]    n_wd = '0;
    logic [6:0]    m_wd = '0;
    logic [RW-1:0] rl_wd = '0;
    logic [4:0]    strap_q, code;
    logic          div_mode, sys_rst, recov;
    logic [7:0]    dn;
    logic [6:0]    dm;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wfr_top #(.TICK_DIV(TD), .RELOAD_W(RW), .PULSE_LEN(PL)) dut (
        .clk_i(clk), .rst_ni(rst_n), .strap_i(strap),
        .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
        .sel_we_i(sel_we), .sel_wdata_i(sel_wd),
        .rcv_n_we_i(n_we), .rcv_n_wdata_i(n_wd),
        .rcv_m_we_i(m_we), .rcv_m_wdata_i(m_wd),
        .reload_we_i(rl_we), .reload_wdata_i(rl_wd),
        .strap_q_o(strap_q), .freq_code_o(code), .div_mode_o(div_mode),
        .div_n_o(dn), .div_m_o(dm), .sys_rst_o(sys_rst), .recovery_o(recov)
    );

    // {ctrl, sel, expected code}
    localparam logic [13:0] VECS [0:5] = '{
        {4'h0, 5'h07, 5'h13},
        {4'h1, 5'h07, 5'h07},
        {4'h1, 5'h1E, 5'h1E},
        {4'h0, 5'h1E, 5'h13},
        {4'h1, 5'h00, 5'h00},
        {4'h4, 5'h05, 5'h13}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [3:0] v);
        @(negedge clk); ctrl_we = 1; ctrl_wd = v;
        @(posedge clk); @(negedge clk); ctrl_we = 0;
    endtask
    task automatic wr_sel(input logic [4:0] v);
        @(negedge clk); sel_we = 1; sel_wd = v;
        @(posedge clk); @(negedge clk); sel_we = 0;
    endtask
    task automatic wr_n(input logic [7:0] v);
        @(negedge clk); n_we = 1; n_wd = v;
        @(posedge clk); @(negedge clk); n_we = 0;
    endtask
    task automatic wr_m(input logic [6:0] v);
        @(negedge clk); m_we = 1; m_wd = v;
        @(posedge clk); @(negedge clk); m_we = 0;
    endtask
    task automatic wr_reload(input logic [RW-1:0] v);
        @(negedge clk); rl_we = 1; rl_wd = v;
        @(posedge clk); @(negedge clk); rl_we = 0;
    endtask

    // called at the negedge after the pulse-starting edge
    task automatic check_pulse(input string req);
        check(req, sys_rst, 1);
        repeat (PL - 1) @(posedge clk);
        @(negedge clk);
        check(req, sys_rst, 1);
        @(posedge clk); @(negedge clk);
        check(req, sys_rst, 0);
    endtask

    // called at the negedge after the arming/restart edge
    task automatic check_timeout(input string req, input int ticks);
        repeat (ticks * TD - 1) @(posedge clk);
        @(negedge clk);
        check(req, recov, 0);
        @(posedge clk); @(negedge clk);
        check(req, recov, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        logic seen;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 strap", strap_q, 0);
        check("R1 code", code, 0);
        check("R1 rst", sys_rst, 0);
        check("R1 recov", recov, 0);
        rst_n = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R2: capture and freeze
        check("R2 strap", strap_q, STRAP);
        strap = 5'h0A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 frozen", strap_q, STRAP);
        check("R2 code", code, STRAP);

        // R3: source select table
        for (int i = 0; i < 6; i++) begin
            wr_ctrl(VECS[i][13:10]);
            wr_sel(VECS[i][9:5]);
            check("R3 code", code, VECS[i][4:0]);
            check("R3 div", div_mode, 0);
        end

        // R8: change-triggered reset
        wr_sel(5'h05);
        check("R8 no change", sys_rst, 0);
        wr_ctrl(4'h8);
        check("R8 no change", sys_rst, 0);
        wr_ctrl(4'h9);
        check("R8 code", code, 5'h05);
        check_pulse("R8 pulse");
        wr_sel(5'h05);
        check("R8 same value", sys_rst, 0);
        wr_sel(5'h0C);
        check_pulse("R8 sel pulse");
        wr_ctrl(4'h1);
        check("R8 clear bit", sys_rst, 0);

        // R4/R6/R7: time-out to strap code
        wr_sel(5'h05);
        wr_reload(8'd3);
        wr_ctrl(4'h3);
        check_timeout("R4 timeout", 3);
        check("R6 code", code, STRAP);
        check("R6 div", div_mode, 0);
        check_pulse("R7 pulse");
        seen = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (sys_rst) seen = 1;
        end
        check("R7 once", seen, 0);
        check("R6 sticky", recov, 1);

        // R9: lockout
        wr_sel(5'h0F);
        check("R9 sel", code, STRAP);
        wr_ctrl(4'h7);
        check("R9 ctrl", div_mode, 0);
        check("R9 recov", recov, 1);
        // R10: exit
        wr_ctrl(4'h1);
        check("R10 recov", recov, 0);
        check("R10 code", code, 5'h05);

        // R6: recovery from N/M
        wr_n(8'hA5);
        wr_m(7'h2C);
        wr_ctrl(4'h5);
        wr_reload(8'd2);
        wr_ctrl(4'h7);
        check_timeout("R6 nm timeout", 2);
        check("R6 div", div_mode, 1);
        check("R6 n", dn, 8'hA5);
        check("R6 m", dm, 7'h2C);
        wr_n(8'h11);
        wr_m(7'h01);
        check("R9 n", dn, 8'hA5);
        check("R9 m", dm, 7'h2C);
        wr_ctrl(4'h5);
        check("R10 div", div_mode, 0);
        check("R10 nm code", code, 5'h05);

        // R5: reload restart
        wr_reload(8'd4);
        wr_ctrl(4'h7);
        repeat (20) @(posedge clk);
        wr_reload(8'd4);
        check_timeout("R5 restart", 4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule